// File: doc/BRIEF.md
# DMA Destination Address and Byte Count Unit

This block keeps the state for the destination side of one DMA channel: the address that the next write cycle will drive, and the number of bytes still to move in the current block. Software loads both registers through simple write strobes and can read them at any time from dedicated outputs. A start pulse begins a block. Before accepting it, the unit checks that the destination address is suitable for the operand size chosen.

While a block is running the unit raises a transfer request. The bus side answers each operand with either a completion strobe or a bus-error strobe. On completion the address advances by the operand size in bytes (1, 2 or 4), but only when address increment is enabled. The address wraps modulo 2^32, and the remaining count falls by the same step. A bus error freezes both registers, so the address output still shows the operand that was not delivered. Three status flags (configuration error, bus error, block done) stay set until software clears them.

Top module: `dma_dest_unit`

## Requirements
- R1: When `stop` is low, `wr_addr_en` loads `dest_addr` and `wr_cnt_en` loads `byte_count` from their write-data inputs, visible on the outputs one cycle later. A register write takes priority over an advance caused by `xfer_done` in the same cycle.
- R2: While `stop` is high, register writes and `start` are ignored.
- R3: `op_size` encodes the operand as 2'b00 byte (step 1), 2'b01 word (step 2), and 2'b10 or 2'b11 long word (step 4).
- R4: On an accepted `xfer_done`, `dest_addr` grows by the step when `inc_en` is 1 and holds when `inc_en` is 0.
- R5: Address arithmetic is unsigned and wraps, so 0xFFFFFFFF plus 1 gives 0x00000000.
- R6: A `start` with a word or long-word size and `dest_addr` bit 0 set raises `cfg_err` and leaves `xfer_req` low.
- R7: `cfg_err` stays set until `clr_status` is pulsed, and every `start` seen while it is set is ignored.
- R8: Each accepted `xfer_done` lowers `byte_count` by the step, or sets it to 0 if the count is not larger than the step. When the count reaches 0, `block_done` is set and `xfer_req` drops on the same edge.
- R9: A `bus_err_in` pulse while `xfer_req` is high sets `bus_err_flag`, drops `xfer_req` and leaves `dest_addr` and `byte_count` unchanged. It wins over a `xfer_done` in the same cycle.
- R10: A `start` with `byte_count` equal to 0 sets `block_done` at once and never raises `xfer_req`.
- R11: Reset clears `xfer_req` and all three flags and leaves `dest_addr` and `byte_count` unchanged.
- R12: `xfer_done` and `bus_err_in` have no effect while `xfer_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| stop | input | 1 | Module disabled: blocks writes and start |
| wr_addr_en | input | 1 | Load destination address |
| addr_wdata | input | 32 | Destination address write data |
| wr_cnt_en | input | 1 | Load byte counter |
| cnt_wdata | input | 32 | Byte counter write data |
| op_size | input | 2 | Operand size code |
| inc_en | input | 1 | Address increment enable |
| start | input | 1 | Begin a block |
| xfer_done | input | 1 | Operand transfer completed |
| bus_err_in | input | 1 | Operand transfer ended by bus error |
| clr_status | input | 1 | Clear all status flags |
| dest_addr | output | 32 | Next destination address |
| byte_count | output | 32 | Bytes left in the block |
| xfer_req | output | 1 | Block active, transfers requested |
| cfg_err | output | 1 | Sticky misalignment flag |
| bus_err_flag | output | 1 | Sticky bus-error flag |
| block_done | output | 1 | Sticky block-complete flag |

## Verification
Every result is held in one register stage. A write, start, completion, bus error or clear that is sampled on a rising edge therefore shows on the outputs right after that edge, and nothing has a longer path. The bench drives all inputs on the falling edge and keeps each strobe for exactly one rising edge. It reads the outputs on the next falling edge, one cycle after the stimulus, and compares them with a step-by-step arithmetic model of address and count. Requests, flags and the final count are checked at that same point for every block in the sweep.

// File: rtl/dma_dest_pkg.sv
package dma_dest_pkg;

    typedef enum logic [1:0] {
        OP_BYTE     = 2'd0,
        OP_WORD     = 2'd1,
        OP_LONG     = 2'd2,
        OP_LONG_ALT = 2'd3
    } op_size_e;

    typedef struct packed {
        logic busy;
        logic cfg_err;
        logic bus_err;
        logic done;
    } flags_t;

    localparam int STEP_W = 3;

endpackage

// File: rtl/dma_step_calc.sv
module dma_step_calc
    import dma_dest_pkg::*;
#(
    parameter int SW = STEP_W
) (
    input  logic [1:0]    op_size,
    input  logic          addr_lsb,
    output logic [SW-1:0] step,
    output logic          misaligned
);
    op_size_e sz;

    always_comb begin
        sz = op_size_e'(op_size);
        unique case (sz)
            OP_BYTE: step = SW'(1);
            OP_WORD: step = SW'(2);
            default: step = SW'(4);
        endcase
        misaligned = (sz != OP_BYTE) && addr_lsb;
    end
endmodule

// File: rtl/dma_addr_adv.sv
module dma_addr_adv #(
    parameter int AW = 32,
    parameter int SW = 3
) (
    input  logic [AW-1:0] addr_q,
    input  logic [SW-1:0] step,
    input  logic          inc_en,
    output logic [AW-1:0] addr_next
);
    logic [AW-1:0] step_ext;

    always_comb begin
        step_ext  = AW'(step);
        addr_next = inc_en ? (addr_q + step_ext) : addr_q;
    end
endmodule

// File: rtl/dma_cnt_adv.sv
module dma_cnt_adv #(
    parameter int CW = 32,
    parameter int SW = 3
) (
    input  logic [CW-1:0] cnt_q,
    input  logic [SW-1:0] step,
    output logic [CW-1:0] cnt_next,
    output logic          empties,
    output logic          is_zero
);
    logic [CW-1:0] step_ext;

    always_comb begin
        step_ext = CW'(step);
        empties  = (cnt_q <= step_ext);
        cnt_next = empties ? '0 : (cnt_q - step_ext);
        is_zero  = (cnt_q == '0);
    end
endmodule

// File: rtl/dma_dest_unit.sv
module dma_dest_unit
    import dma_dest_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic              wr_addr_en,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              wr_cnt_en,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic [1:0]        op_size,
    input  logic              inc_en,
    input  logic              start,
    input  logic              xfer_done,
    input  logic              bus_err_in,
    input  logic              clr_status,
    output logic [ADDR_W-1:0] dest_addr,
    output logic [CNT_W-1:0]  byte_count,
    output logic              xfer_req,
    output logic              cfg_err,
    output logic              bus_err_flag,
    output logic              block_done
);
    localparam int SW = STEP_W;

    typedef struct packed {
        flags_t            fl;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t st_d, st_q;

    logic [SW-1:0]     step;
    logic              misaligned;
    logic [ADDR_W-1:0] addr_next;
    logic [CNT_W-1:0]  cnt_next;
    logic              cnt_empties;
    logic              cnt_zero;

    dma_step_calc #(.SW(SW)) u_step (
        .op_size    (op_size),
        .addr_lsb   (st_q.addr[0]),
        .step       (step),
        .misaligned (misaligned)
    );

    dma_addr_adv #(.AW(ADDR_W), .SW(SW)) u_addr (
        .addr_q    (st_q.addr),
        .step      (step),
        .inc_en    (inc_en),
        .addr_next (addr_next)
    );

    dma_cnt_adv #(.CW(CNT_W), .SW(SW)) u_cnt (
        .cnt_q    (st_q.cnt),
        .step     (step),
        .cnt_next (cnt_next),
        .empties  (cnt_empties),
        .is_zero  (cnt_zero)
    );

    always_comb begin
        st_d = st_q;

        if (clr_status) begin
            st_d.fl.cfg_err = 1'b0;
            st_d.fl.bus_err = 1'b0;
            st_d.fl.done    = 1'b0;
        end

        if (st_q.fl.busy) begin
            if (bus_err_in) begin
                st_d.fl.bus_err = 1'b1;
                st_d.fl.busy    = 1'b0;
            end else if (xfer_done) begin
                st_d.addr = addr_next;
                st_d.cnt  = cnt_next;
                if (cnt_empties) begin
                    st_d.fl.busy = 1'b0;
                    st_d.fl.done = 1'b1;
                end
            end
        end else if (start && !stop && !st_q.fl.cfg_err) begin
            if (misaligned) begin
                st_d.fl.cfg_err = 1'b1;
            end else if (cnt_zero) begin
                st_d.fl.done = 1'b1;
            end else begin
                st_d.fl.busy = 1'b1;
                st_d.fl.done = 1'b0;
            end
        end

        if (!stop && wr_addr_en) begin
            st_d.addr = addr_wdata;
        end
        if (!stop && wr_cnt_en) begin
            st_d.cnt = cnt_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dest_addr    = st_q.addr;
    assign byte_count   = st_q.cnt;
    assign xfer_req     = st_q.fl.busy;
    assign cfg_err      = st_q.fl.cfg_err;
    assign bus_err_flag = st_q.fl.bus_err;
    assign block_done   = st_q.fl.done;

endmodule

// File: rtl/dma_dest_unit_chk.sv
module dma_dest_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop,
    input logic              wr_addr_en,
    input logic              wr_cnt_en,
    input logic [1:0]        op_size,
    input logic              inc_en,
    input logic              start,
    input logic              xfer_done,
    input logic              bus_err_in,
    input logic              clr_status,
    input logic [ADDR_W-1:0] dest_addr,
    input logic [CNT_W-1:0]  byte_count,
    input logic              xfer_req,
    input logic              cfg_err,
    input logic              bus_err_flag,
    input logic              block_done
);
    logic [CNT_W-1:0]  stp_c;
    logic [ADDR_W-1:0] stp_a;
    logic [CNT_W-1:0]  cnt_pred;
    logic              any_wr;

    always_comb begin
        stp_c    = (op_size == 2'd0) ? CNT_W'(1) : (op_size == 2'd1) ? CNT_W'(2) : CNT_W'(4);
        stp_a    = ADDR_W'(stp_c);
        cnt_pred = (byte_count > stp_c) ? (byte_count - stp_c) : '0;
        any_wr   = !stop && (wr_addr_en || wr_cnt_en);
    end

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && !bus_err_in && inc_en && !(wr_addr_en && !stop)
        |=> dest_addr == $past(dest_addr + stp_a));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && !inc_en && !(wr_addr_en && !stop)
        |=> $stable(dest_addr));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && !bus_err_in && !(wr_cnt_en && !stop)
        |=> byte_count == $past(cnt_pred));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> !xfer_req);

    // R6
    misalign_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !stop && !xfer_req && (op_size != 2'd0) && dest_addr[0] && !cfg_err
        |=> cfg_err && !xfer_req);

    // R7
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err && !clr_status |=> cfg_err);

    // R7
    cfg_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err && !xfer_req |=> !xfer_req);

    // R9
    bus_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && bus_err_in && !any_wr
        |=> $stable(dest_addr) && $stable(byte_count) && !xfer_req && bus_err_flag);

    // R12
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_req && !any_wr |=> $stable(dest_addr) && $stable(byte_count));

    // R2
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !xfer_req |=> !xfer_req && $stable(dest_addr) && $stable(byte_count));

endmodule

bind dma_dest_unit dma_dest_unit_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop         (stop),
    .wr_addr_en   (wr_addr_en),
    .wr_cnt_en    (wr_cnt_en),
    .op_size      (op_size),
    .inc_en       (inc_en),
    .start        (start),
    .xfer_done    (xfer_done),
    .bus_err_in   (bus_err_in),
    .clr_status   (clr_status),
    .dest_addr    (dest_addr),
    .byte_count   (byte_count),
    .xfer_req     (xfer_req),
    .cfg_err      (cfg_err),
    .bus_err_flag (bus_err_flag),
    .block_done   (block_done)
);

// File: tb/dma_dest_unit_tb.sv
module dma_dest_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop = 1'b0;
    logic        wr_addr_en = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic        wr_cnt_en = 1'b0;
    logic [31:0] cnt_wdata = '0;
    logic [1:0]  op_size = 2'd0;
    logic        inc_en = 1'b0;
    logic        start = 1'b0;
    logic        xfer_done = 1'b0;
    logic        bus_err_in = 1'b0;
    logic        clr_status = 1'b0;
    logic [31:0] dest_addr;
    logic [31:0] byte_count;
    logic        xfer_req;
    logic        cfg_err;
    logic        bus_err_flag;
    logic        block_done;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    dma_dest_unit u_dut (
        .clk(clk), .rst_n(rst_n), .stop(stop),
        .wr_addr_en(wr_addr_en), .addr_wdata(addr_wdata),
        .wr_cnt_en(wr_cnt_en), .cnt_wdata(cnt_wdata),
        .op_size(op_size), .inc_en(inc_en), .start(start),
        .xfer_done(xfer_done), .bus_err_in(bus_err_in), .clr_status(clr_status),
        .dest_addr(dest_addr), .byte_count(byte_count), .xfer_req(xfer_req),
        .cfg_err(cfg_err), .bus_err_flag(bus_err_flag), .block_done(block_done)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [31:0] a, input logic [31:0] c);
        wr_addr_en = 1'b1; addr_wdata = a;
        wr_cnt_en  = 1'b1; cnt_wdata  = c;
        tick();
        wr_addr_en = 1'b0; wr_cnt_en = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    endtask

    task automatic pulse_err();
        bus_err_in = 1'b1; tick(); bus_err_in = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_status = 1'b1; tick(); clr_status = 1'b0;
    endtask

    function automatic logic [31:0] step_of(input int sz);
        return (sz == 0) ? 32'd1 : (sz == 1) ? 32'd2 : 32'd4;
    endfunction

    task automatic run_block(input int sz, input int inc, input logic [31:0] a0, input logic [31:0] c0);
        logic [31:0] ea, ec, st;
        op_size = 2'(sz);
        inc_en  = 1'(inc);
        load(a0, c0);
        check("R1 addr load", dest_addr, a0);
        check("R1 count load", byte_count, c0);
        pulse_start();
        if (sz != 0 && a0[0]) begin
            check("R6 cfg_err", {31'd0, cfg_err}, 32'd1);
            check("R6 xfer_req", {31'd0, xfer_req}, 32'd0);
            pulse_clr();
            return;
        end
        if (c0 == 0) begin
            check("R10 block_done", {31'd0, block_done}, 32'd1);
            check("R10 xfer_req", {31'd0, xfer_req}, 32'd0);
            pulse_clr();
            return;
        end
        check("R8 request raised", {31'd0, xfer_req}, 32'd1);
        ea = a0; ec = c0; st = step_of(sz);
        for (int k = 0; k < 16 && ec != 0; k++) begin
            pulse_done();
            ea = (inc != 0) ? ea + st : ea;
            ec = (ec > st) ? ec - st : 32'd0;
            if (inc == 0)
                check("R4 addr hold", dest_addr, ea);
            else if (ea < a0)
                check("R5 addr wrap", dest_addr, ea);
            else
                check("R3 addr step", dest_addr, ea);
            check("R8 count", byte_count, ec);
            check("R8 request", {31'd0, xfer_req}, (ec != 0) ? 32'd1 : 32'd0);
            check("R8 block_done", {31'd0, block_done}, (ec == 0) ? 32'd1 : 32'd0);
        end
        pulse_clr();
    endtask

    logic [31:0] addr_list [6];
    logic [31:0] cnt_list  [6];

    initial begin
        addr_list = '{32'h0, 32'h2, 32'h13, 32'h1000_0006, 32'hFFFF_FFFE, 32'hFFFF_FFFF};
        cnt_list  = '{32'd0, 32'd1, 32'd3, 32'd4, 32'd7, 32'd10};

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11: control state after reset
        check("R11 xfer_req", {31'd0, xfer_req}, 32'd0);
        check("R11 cfg_err", {31'd0, cfg_err}, 32'd0);
        check("R11 bus_err_flag", {31'd0, bus_err_flag}, 32'd0);
        check("R11 block_done", {31'd0, block_done}, 32'd0);

        for (int sz = 0; sz < 4; sz++)
            for (int inc = 0; inc < 2; inc++)
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        run_block(sz, inc, addr_list[i], cnt_list[j]);

        // R5: explicit byte wrap
        op_size = 2'd0; inc_en = 1'b1;
        load(32'hFFFF_FFFF, 32'd2);
        pulse_start();
        pulse_done();
        check("R5 wrap to zero", dest_addr, 32'h0);
        pulse_done();
        pulse_clr();

        // R12: strobes while idle
        op_size = 2'd1;
        load(32'h40, 32'd8);
        pulse_done();
        pulse_err();
        check("R12 addr", dest_addr, 32'h40);
        check("R12 count", byte_count, 32'd8);
        check("R12 bus_err_flag", {31'd0, bus_err_flag}, 32'd0);

        // R2: stop blocks writes and start
        stop = 1'b1;
        load(32'h999, 32'd5);
        pulse_start();
        check("R2 addr", dest_addr, 32'h40);
        check("R2 count", byte_count, 32'd8);
        check("R2 xfer_req", {31'd0, xfer_req}, 32'd0);
        stop = 1'b0;

        // R6 then R7
        load(32'h41, 32'd8);
        pulse_start();
        check("R6 cfg_err", {31'd0, cfg_err}, 32'd1);
        load(32'h40, 32'd8);
        pulse_start();
        check("R7 start ignored", {31'd0, xfer_req}, 32'd0);
        check("R7 sticky", {31'd0, cfg_err}, 32'd1);
        pulse_clr();
        check("R7 cleared", {31'd0, cfg_err}, 32'd0);
        pulse_start();
        check("R7 start after clear", {31'd0, xfer_req}, 32'd1);
        pulse_done();
        check("R4 word step", dest_addr, 32'h42);

        // R9: bus error hold
        pulse_err();
        check("R9 addr", dest_addr, 32'h42);
        check("R9 count", byte_count, 32'd6);
        check("R9 flag", {31'd0, bus_err_flag}, 32'd1);
        check("R9 xfer_req", {31'd0, xfer_req}, 32'd0);
        pulse_clr();
        pulse_start();
        xfer_done = 1'b1; bus_err_in = 1'b1;
        tick();
        xfer_done = 1'b0; bus_err_in = 1'b0;
        check("R9 wins addr", dest_addr, 32'h42);
        check("R9 wins count", byte_count, 32'd6);
        check("R9 wins flag", {31'd0, bus_err_flag}, 32'd1);
        pulse_clr();

        // R1: write beats advance
        pulse_start();
        xfer_done = 1'b1; wr_addr_en = 1'b1; addr_wdata = 32'h800;
        tick();
        xfer_done = 1'b0; wr_addr_en = 1'b0;
        check("R1 write priority", dest_addr, 32'h800);
        check("R1 count advanced", byte_count, 32'd4);

        // R11: reset mid-block keeps data
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R11 addr kept", dest_addr, 32'h800);
        check("R11 count kept", byte_count, 32'd4);
        check("R11 request cleared", {31'd0, xfer_req}, 32'd0);

        summary();
        $finish;
    end
endmodule